// File: doc/BRIEF.md
# Card Interface Status Register with Interrupt

This block keeps the 8-bit status word of a smart card interface. Three of its bits show live conditions: whether a card is present, the level of the card I/O line, and whether a card session is active. The other five bits are sticky event flags. They record a card insertion or removal, a supervisor fault, an overload or overheat during a session, a card that stays silent past its answer window, and a card that answers too early.

The active-low interrupt line goes low while any of four event flags is set. It also stays low for as long as the supply supervisor is active, whether or not the word has been read.

The serial bus front end is outside this block. It sends a single-cycle read strobe when the status byte of a read transaction has been transferred. On that strobe the block captures the status word as it stands, and it clears the event flags in the same edge. An event that arrives together with the strobe is kept, so no event is lost.

Top module: `card_status_reg`

## Requirements
- R1: After reset, `status_o` and `rd_data_o` are all zero and `irq_no` is high.
- R2: Status bit 0 (card present), bit 2 (I/O level) and bit 7 (session active) show the value their input had one clock earlier. These bits are never latched.
- R3: Status bit 1 is set one clock after `card_present_i` differs from status bit 0. This covers both insertion and removal.
- R4: Status bit 4 is set one clock after `overload_i` is high together with `card_active_i`. An overload while `card_active_i` is low leaves bit 4 unchanged.
- R5: Status bit 5 is set one clock after a `mute_evt_i` pulse. Status bit 6 is set one clock after an `early_evt_i` pulse.
- R6: Each of the event bits 1, 3, 4, 5 and 6 stays set until a read strobe. One clock after the strobe it reads zero, unless its own set condition was present in the strobe cycle.
- R7: One clock after `rd_strobe_i`, `rd_data_o` holds the `status_o` value of the strobe cycle, taken before the clear. It keeps that value until the next strobe.
- R8: An event whose set condition coincides with a read strobe is still set one clock later.
- R9: `irq_no` is low exactly while bit 1, 4, 5 or 6 is set or the supervisor was active in the previous cycle. Otherwise it is high.
- R10: Status bit 3 is set one clock after any cycle with `supervisor_i` high. Reads do not clear it while the supervisor stays active. The first read after the supervisor goes inactive clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_present_i | input | 1 | Card presence level |
| io_level_i | input | 1 | Card I/O line level |
| card_active_i | input | 1 | Card session active |
| supervisor_i | input | 1 | Supply supervisor active / fault |
| overload_i | input | 1 | Overload or overheat event |
| mute_evt_i | input | 1 | Card did not answer in its window |
| early_evt_i | input | 1 | Card answered too early |
| rd_strobe_i | input | 1 | Status byte transferred on the serial bus |
| status_o | output | 8 | Current status word |
| rd_data_o | output | 8 | Status word captured at the last read |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Every result of this block is due exactly one clock after the stimulus that causes it. This holds for live bits, event latching, clear-on-read, the read capture and the interrupt, because each one passes through a single register stage.

The bench changes inputs on the falling edge and lets one rising edge pass. It then checks every output on the next falling edge against a model that applies the requirements to the inputs it has just driven. In this way each check lands on the first cycle in which the result is due.

// File: rtl/card_status_pkg.sv
package card_status_pkg;
  localparam int STAT_W = 8;
  // status word bit positions
  localparam int ST_PRES   = 0;
  localparam int ST_PRESL  = 1;
  localparam int ST_IO     = 2;
  localparam int ST_SUPL   = 3;
  localparam int ST_PROT   = 4;
  localparam int ST_MUTE   = 5;
  localparam int ST_EARLY  = 6;
  localparam int ST_ACTIVE = 7;
  // live sampler lanes
  localparam int LIVE_W = 4;
  localparam int LV_PRES = 0;
  localparam int LV_IO   = 1;
  localparam int LV_ACT  = 2;
  localparam int LV_SUP  = 3;
  // sticky event lanes
  localparam int EVT_W = 5;
  localparam int EV_PRESL = 0;
  localparam int EV_SUPL  = 1;
  localparam int EV_PROT  = 2;
  localparam int EV_MUTE  = 3;
  localparam int EV_EARLY = 4;
  // events that pull the interrupt (supervisor handled by live level)
  localparam logic [EVT_W-1:0] IRQ_MASK =
    EVT_W'((1 << EV_PRESL) | (1 << EV_PROT) | (1 << EV_MUTE) | (1 << EV_EARLY));
endpackage

// File: rtl/cs_live_sync.sv
module cs_live_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cs_sticky_bank.sv
module cs_sticky_bank #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    // set wins over clear so a coincident event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= 1'b0;
      else         q_o[g] <= (q_o[g] & ~clr_i) | set_i[g];
    end
  end
endmodule

// File: rtl/card_status_reg.sv
module card_status_reg
  import card_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_present_i,
  input  logic              io_level_i,
  input  logic              card_active_i,
  input  logic              supervisor_i,
  input  logic              overload_i,
  input  logic              mute_evt_i,
  input  logic              early_evt_i,
  input  logic              rd_strobe_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_no
);
  logic [LIVE_W-1:0] live_d, live_q;
  logic [EVT_W-1:0]  evt_set, evt_q;

  always_comb begin
    live_d          = '0;
    live_d[LV_PRES] = card_present_i;
    live_d[LV_IO]   = io_level_i;
    live_d[LV_ACT]  = card_active_i;
    live_d[LV_SUP]  = supervisor_i;
  end

  cs_live_sync #(.W(LIVE_W)) u_live (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (live_d),
    .q_o   (live_q)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[EV_PRESL] = card_present_i ^ live_q[LV_PRES];
    evt_set[EV_SUPL]  = supervisor_i;
    evt_set[EV_PROT]  = overload_i & card_active_i;
    evt_set[EV_MUTE]  = mute_evt_i;
    evt_set[EV_EARLY] = early_evt_i;
  end

  cs_sticky_bank #(.W(EVT_W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set),
    .clr_i (rd_strobe_i),
    .q_o   (evt_q)
  );

  always_comb begin
    status_o            = '0;
    status_o[ST_PRES]   = live_q[LV_PRES];
    status_o[ST_PRESL]  = evt_q[EV_PRESL];
    status_o[ST_IO]     = live_q[LV_IO];
    status_o[ST_SUPL]   = evt_q[EV_SUPL];
    status_o[ST_PROT]   = evt_q[EV_PROT];
    status_o[ST_MUTE]   = evt_q[EV_MUTE];
    status_o[ST_EARLY]  = evt_q[EV_EARLY];
    status_o[ST_ACTIVE] = live_q[LV_ACT];
  end

  // capture pre-clear word on the strobe edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rd_data_o <= '0;
    else if (rd_strobe_i) rd_data_o <= status_o;
  end

  assign irq_no = ~(|(evt_q & IRQ_MASK) | live_q[LV_SUP]);
endmodule

// File: rtl/card_status_chk.sv
module card_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       card_present_i,
  input logic       io_level_i,
  input logic       card_active_i,
  input logic       supervisor_i,
  input logic       overload_i,
  input logic       mute_evt_i,
  input logic       rd_strobe_i,
  input logic [7:0] status_o,
  input logic [7:0] rd_data_o,
  input logic       irq_no
);
  AST_LIVE_PRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[0] == $past(card_present_i) && status_o[2] == $past(io_level_i)
             && status_o[7] == $past(card_active_i)); // R2
  AST_PRESL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_present_i != status_o[0]) |=> status_o[1]); // R3
  AST_PROT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_active_i && !status_o[4]) |=> !status_o[4]); // R4
  AST_MUTE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_evt_i |=> status_o[5]); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_strobe_i && status_o[4]) |=> status_o[4]); // R6
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> rd_data_o == $past(status_o)); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> $stable(rd_data_o)); // R7
  AST_RD_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && mute_evt_i) |=> status_o[5]); // R8
  AST_IRQ_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] || status_o[4] || status_o[5] || status_o[6]) |-> !irq_no); // R9
  AST_SUP_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supervisor_i |=> !irq_no && status_o[3]); // R10
endmodule

bind card_status_reg card_status_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .card_present_i(card_present_i),
  .io_level_i    (io_level_i),
  .card_active_i (card_active_i),
  .supervisor_i  (supervisor_i),
  .overload_i    (overload_i),
  .mute_evt_i    (mute_evt_i),
  .rd_strobe_i   (rd_strobe_i),
  .status_o      (status_o),
  .rd_data_o     (rd_data_o),
  .irq_no        (irq_no)
);

// File: tb/card_status_reg_test.sv
`timescale 1ns/1ps
module card_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pres = 0, io = 0, act = 0, sup = 0, ovl = 0, mute = 0, early = 0, rd = 0;
  logic [7:0] status, rd_data;
  logic irq_n;
  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic m_pres = 0, m_io = 0, m_act = 0, m_sup = 0;
  logic m_presl = 0, m_supl = 0, m_prot = 0, m_mute = 0, m_early = 0;
  logic [7:0] m_rd = '0;

  always #5 clk = ~clk;

  card_status_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .card_present_i(pres), .io_level_i(io),
    .card_active_i(act), .supervisor_i(sup), .overload_i(ovl),
    .mute_evt_i(mute), .early_evt_i(early), .rd_strobe_i(rd),
    .status_o(status), .rd_data_o(rd_data), .irq_no(irq_n)
  );

  function automatic logic [7:0] pack();
    return {m_act, m_early, m_mute, m_prot, m_supl, m_io, m_presl, m_pres};
  endfunction

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "status", status, pack());
    check(req, "rd_data", rd_data, m_rd);
    check(req, "irq_n", {7'd0, irq_n},
          {7'd0, ~(m_presl | m_prot | m_mute | m_early | m_sup)});
  endtask

  // drive at negedge, one rising edge, check at next negedge
  task automatic step(string req, logic p, logic i, logic a, logic s,
                      logic o, logic mu, logic e, logic r);
    logic [7:0] cur;
    pres = p; io = i; act = a; sup = s; ovl = o; mute = mu; early = e; rd = r;
    cur = pack();
    if (r) m_rd = cur;
    m_presl = (m_presl & ~r) | (p ^ m_pres);
    m_supl  = (m_supl  & ~r) | s;
    m_prot  = (m_prot  & ~r) | (o & a);
    m_mute  = (m_mute  & ~r) | mu;
    m_early = (m_early & ~r) | e;
    m_pres = p; m_io = i; m_act = a; m_sup = s;
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: live bits, every combination
    for (int v = 0; v < 8; v++) begin
      step("R2", v[0], v[1], v[2], 0, 0, 0, 0, 0);
      step("R2", v[0], v[1], v[2], 0, 0, 0, 0, 0);
    end
    step("R6", m_pres, m_io, 1, 0, 0, 0, 0, 1);
    step("R6", m_pres, m_io, 1, 0, 0, 0, 0, 0);

    // R3 R5 R9 R7 R6: every subset of event sources
    for (int e = 0; e < 32; e++) begin
      logic np;
      np = e[4] ? ~m_pres : m_pres;
      step("R5", np, e[0], 1, e[3], e[0], e[1], e[2], 0);
      step("R3", np, 0, 1, 0, 0, 0, 0, 0);
      step("R9", np, 0, 1, 0, 0, 0, 0, 0);
      step("R7", np, 0, 1, 0, 0, 0, 0, 1);
      step("R6", np, 0, 1, 0, 0, 0, 0, 0);
    end

    // R4: overload without session ignored, then with session latched
    step("R4", m_pres, 0, 0, 0, 1, 0, 0, 0);
    step("R4", m_pres, 0, 0, 0, 0, 0, 0, 0);
    step("R4", m_pres, 0, 1, 0, 1, 0, 0, 0);
    step("R4", m_pres, 0, 1, 0, 0, 0, 0, 1);

    // R8: events coincident with the read strobe survive
    for (int e = 1; e < 8; e++) begin
      step("R8", m_pres, 0, 1, 0, e[0], e[1], e[2], 1);
      step("R8", m_pres, 0, 1, 0, 0, 0, 0, 0);
      step("R8", m_pres, 0, 1, 0, 0, 0, 0, 1);
      step("R8", m_pres, 0, 1, 0, 0, 0, 0, 0);
    end

    // R10: supervisor held through reads, then released
    for (int k = 0; k < 4; k++) step("R10", m_pres, 0, 0, 1, 0, 0, 0, k[0]);
    step("R10", m_pres, 0, 0, 0, 0, 0, 0, 0);
    step("R10", m_pres, 0, 0, 0, 0, 0, 0, 1);
    step("R10", m_pres, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule